// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block watches a port of general-purpose input pins and turns selected pin conditions into interrupt requests. Every pin has its own control word holding a 4-bit detection mode. The mode can disable the pin, watch for a low or high level, or watch for a rising, falling or either edge. Each pin input first passes through a two-flop synchroniser. The selected condition is then detected on the synchronised value and stored in a shared status register that holds one flag per pin. Software clears flags by writing ones to the status register. A single interrupt output stays high while any flag is set.

Software reaches the registers through a small 32-bit request/response bus. A request is accepted on any cycle in which `req_valid` is high, because `req_ready` is tied high and the block never applies back-pressure. A read request returns its data one cycle later with `rsp_valid` high for exactly one cycle. The response has no ready signal, so the requester must take the data in that cycle. Writes produce no response. Address bits 1:0 are ignored, so register selection works on 32-bit words.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0, the status register reads 0 and `irq_o` is low.
- R2: The control word for pin n sits at byte address 4*n. Its mode occupies bits 19:16 and reads back as written. All other bits read as 0.
- R3: The status register sits at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged. A write of all ones clears every flag.
- R4: Mode 0x9 sets the pin's flag on a 0-to-1 change of the synchronised pin. A 1-to-0 change does not set it.
- R5: Mode 0xA sets the flag on a 1-to-0 change only.
- R6: Mode 0xB sets the flag on a change in either direction.
- R7: Mode 0x8 sets the flag on every cycle the synchronised pin is 0. A clear written while the pin is held low leaves the flag set.
- R8: Mode 0xC sets the flag on every cycle the synchronised pin is 1.
- R9: Mode 0x0, and any code other than 0x8 to 0xC, never sets a flag. Writing 0 to a control word disables that pin.
- R10: When a pin event and a write-1 clear of the same bit happen in the same cycle, the flag stays set. Other bits cleared by the same write still clear.
- R11: `irq_o` is high exactly when at least one status flag is set.
- R12: Reads from addresses that hold no register (0x80 to 0x9C and above 0xA0) return 0. A read answers on the next cycle with `rsp_valid` high for one cycle.
- R13: After a pin changes before clock edge k, the resulting flag and `irq_o` are first visible after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The bench uses the default parameters: NUM_PINS = 32 and ADDR_W = 8. With 32 pins, pin 31 drives the top status bit, and the last control word at 0x7C sits directly below the unmapped window that starts at 0x80. The 8-bit address also reaches the unmapped space above the status register. The bench runs directed cases for each mode, the clear-versus-event collision and the exact three-edge latency. A random phase then mixes every mode, including unlisted codes, with pin toggles and clears, and compares the result against a cycle model written in the bench.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int MODE_W   = 4;
  localparam int MODE_LSB = 16;
  localparam int STAT_ADDR = 'hA0;

  typedef enum logic [MODE_W-1:0] {
    IRQ_OFF  = 4'h0,
    IRQ_LVL0 = 4'h8,
    IRQ_RISE = 4'h9,
    IRQ_FALL = 4'hA,
    IRQ_BOTH = 4'hB,
    IRQ_LVL1 = 4'hC
  } irq_mode_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           pin_s,
  input  logic [N-1:0][MODE_W-1:0] mode,
  output logic [N-1:0]           evt
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pin_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      case (mode[i])
        IRQ_LVL0: evt[i] = ~pin_s[i];
        IRQ_RISE: evt[i] = pin_s[i] & ~prev[i];
        IRQ_FALL: evt[i] = ~pin_s[i] & prev[i];
        IRQ_BOTH: evt[i] = pin_s[i] ^ prev[i];
        IRQ_LVL1: evt[i] = pin_s[i];
        default:  evt[i] = 1'b0;
      endcase
    end

    // R4
    rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == IRQ_RISE && pin_s[i] == prev[i]) |-> !evt[i]);

    // R8
    lvl1_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == IRQ_LVL1 && pin_s[i]) |-> evt[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [N-1:0]             evt,
  output logic [N-1:0][MODE_W-1:0] mode,
  output logic [N-1:0]             flags,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int PIN_W    = (N > 1) ? $clog2(N) : 1;
  localparam int STAT_IDX = STAT_ADDR / 4;

  logic [IDX_W-1:0]  idx;
  logic              pin_hit;
  logic              stat_hit;
  logic              stat_wr;
  logic [PIN_W-1:0]  pin_idx;
  logic [DATA_W-1:0] rd_mux;

  assign idx      = req_addr[ADDR_W-1:2];
  assign pin_hit  = int'(idx) < N;
  assign stat_hit = int'(idx) == STAT_IDX;
  assign pin_idx  = idx[PIN_W-1:0];
  assign stat_wr  = req_valid && req_write && stat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (req_valid && req_write && pin_hit) begin
      mode[pin_idx] <= req_wdata[MODE_LSB +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~(stat_wr ? req_wdata[N-1:0] : '0)) | evt;
  end

  always_comb begin
    rd_mux = '0;
    if (pin_hit)       rd_mux[MODE_LSB +: MODE_W] = mode[pin_idx];
    else if (stat_hit) rd_mux[N-1:0] = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ((req_wdata[N-1:0] & evt) == '0)) |=>
      ((flags & $past(req_wdata[N-1:0])) == '0));

  // R10
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && evt == '0) |=> $stable(flags));

  // R12
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]             pin_s;
  logic [NUM_PINS-1:0]             evt;
  logic [NUM_PINS-1:0]             flags;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode;

  assign req_ready = 1'b1;

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  gpio_irq_detect #(.N(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode), .evt(evt)
  );

  gpio_irq_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .evt(evt), .mode(mode), .flags(flags),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign irq_o = |flags;

  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(req_valid && req_write));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  // cycle model built from the requirements
  logic [3:0]   m_mode [N];
  logic [N-1:0] m_s1, m_s2, m_p, m_flags;

  function automatic logic ev_of(logic [3:0] md, logic s, logic p);
    case (md)
      4'h8: return !s;
      4'h9: return s && !p;
      4'hA: return !s && p;
      4'hB: return s != p;
      4'hC: return s;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] ev;
    logic [N-1:0] clr;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_mode[i] = 4'h0;
      m_s1 = '0; m_s2 = '0; m_p = '0; m_flags = '0;
    end else begin
      for (int i = 0; i < N; i++) ev[i] = ev_of(m_mode[i], m_s2[i], m_p[i]);
      clr = '0;
      if (req_valid && req_write) begin
        if (req_addr[7:2] < 6'd32) m_mode[req_addr[6:2]] = req_wdata[19:16];
        if (req_addr[7:2] == 6'd40) clr = req_wdata;
      end
      m_flags = (m_flags & ~clr) | ev;
      m_p = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [3:0] codes [8];
    codes = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h3, 4'hE};
    void'($urandom(32'h5EED));

    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd(8'hA0, d, v); chk("R1 status", d, 0);
    rd(8'h0C, d, v); chk("R1 ctrl", d, 0);
    chk("R12 rsp_valid", {31'b0, v}, 1);
    chk("R12 req_ready", {31'b0, req_ready}, 1);

    // R2 readback and masking; unlisted code 0xF is disabled (R9)
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d, v); chk("R2 ctrl mask", d, 32'h000F_0000);
    pin_i[5] = 1'b1; tick(4); pin_i[5] = 1'b0; tick(4);
    chk("R9 unlisted code", {31'b0, irq_o}, 0);
    wr(8'h7C, 32'h000C_0000);
    rd(8'h7C, d, v); chk("R2 last ctrl", d, 32'h000C_0000);
    wr(8'h7C, 32'h0);

    // R4 / R13 rising on pin 2
    wr(8'h08, 32'h0009_0000);
    pin_i[2] = 1'b1;
    tick(2); chk("R13 before k+2", {31'b0, irq_o}, 0);
    tick(1); chk("R13 at k+2", {31'b0, irq_o}, 1);
    rd(8'hA0, d, v); chk("R4 rise flag", d, 32'h4);
    wr(8'hA0, 32'h0);
    rd(8'hA0, d, v); chk("R3 write0 keeps", d, 32'h4);
    wr(8'hA0, 32'h4);
    rd(8'hA0, d, v); chk("R3 w1c", d, 0);
    pin_i[2] = 1'b0; tick(5);
    rd(8'hA0, d, v); chk("R4 fall ignored", d, 0);

    // R5 falling on pin 7
    wr(8'h1C, 32'h000A_0000);
    pin_i[7] = 1'b1; tick(5);
    rd(8'hA0, d, v); chk("R5 rise ignored", d, 0);
    pin_i[7] = 1'b0; tick(4);
    rd(8'hA0, d, v); chk("R5 fall flag", d, 32'h80);
    wr(8'hA0, 32'h80);

    // R6 either edge on pin 9
    wr(8'h24, 32'h000B_0000);
    pin_i[9] = 1'b1; tick(4);
    rd(8'hA0, d, v); chk("R6 rise", d, 32'h200);
    wr(8'hA0, 32'h200); tick(2);
    rd(8'hA0, d, v); chk("R6 cleared", d, 0);
    pin_i[9] = 1'b0; tick(4);
    rd(8'hA0, d, v); chk("R6 fall", d, 32'h200);
    wr(8'hA0, 32'h200);

    // R7 level low on pin 12 (pin already 0)
    wr(8'h30, 32'h0008_0000); tick(2);
    wr(8'hA0, 32'h1000);
    rd(8'hA0, d, v); chk("R7 clear while low", d, 32'h1000);
    pin_i[12] = 1'b1; tick(4);
    wr(8'hA0, 32'h1000); tick(2);
    rd(8'hA0, d, v); chk("R7 released", d, 0);
    wr(8'h30, 32'h0);
    pin_i[12] = 1'b0; tick(5);
    rd(8'hA0, d, v); chk("R9 write0 disables", d, 0);

    // R8 level high on pin 31
    wr(8'h7C, 32'h000C_0000);
    pin_i[31] = 1'b1; tick(4);
    wr(8'hA0, 32'h8000_0000);
    rd(8'hA0, d, v); chk("R8 level high", d, 32'h8000_0000);
    pin_i[31] = 1'b0; tick(4);
    wr(8'hA0, 32'h8000_0000);
    rd(8'hA0, d, v); chk("R8 released", d, 0);
    wr(8'h7C, 32'h0);

    // R10 event and clear in the same cycle
    wr(8'h10, 32'h0009_0000);
    pin_i[2] = 1'b1; tick(4);
    pin_i[4] = 1'b1;
    tick(2);
    wr(8'hA0, 32'h14);
    rd(8'hA0, d, v); chk("R10 collision", d, 32'h10);

    // R12 unmapped reads, R11 irq and all-ones clear
    rd(8'h80, d, v); chk("R12 0x80", d, 0);
    rd(8'h9C, d, v); chk("R12 0x9C", d, 0);
    rd(8'hA4, d, v); chk("R12 0xA4", d, 0);
    rd(8'hFC, d, v); chk("R12 0xFC", d, 0);
    chk("R11 irq set", {31'b0, irq_o}, 1);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk("R11 irq clear", {31'b0, irq_o}, 0);
    rd(8'hA0, d, v); chk("R3 all ones", d, 0);

    // random phase against the model
    for (int i = 0; i < N; i++) wr(8'(i * 4), {12'b0, codes[$urandom_range(7)], 16'b0});
    for (int c = 0; c < 3000; c++) begin
      chk("R11 random irq", {31'b0, irq_o}, {31'b0, |m_flags});
      pin_i = pin_i ^ ($urandom & $urandom);
      if ($urandom_range(7) == 0) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hA0; req_wdata = $urandom;
      end else begin
        req_valid = 1'b0; req_write = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; req_write = 1'b0;
    for (int i = 0; i < N; i++) wr(8'(i * 4), 32'h0);
    tick(5);
    rd(8'hA0, d, v); chk("R4 R5 R6 R7 R8 random status", d, m_flags);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk("R3 random clear", {31'b0, irq_o}, 0);

    summary();
  end
endmodule